// File: doc/BRIEF.md
# Signed Approximate Multiplier with Selectable Carry-Propagate Stage

This block multiplies two signed W-bit two's-complement operands and returns a 2W-bit product one clock later. The operands may be read as any fixed-point format. Two operands with 4 integer bits and 60 fraction bits, for example, give a product with 8 integer bits and 120 fraction bits. The block has three stages. A partial-product stage builds one row per multiplier bit from plain shifted copies of the multiplicand, with no recoding. A tree of full-adder (3:2) compressors then reduces those rows, exactly, to two rows. A final carry-propagate adder adds the two rows.

The final adder is the only place where accuracy can be lost, and a parameter chooses its type:
- Code 0 is an exact adder left to prefix synthesis.
- Code 1 is a windowed speculative adder. Each sum bit sees only the K bits at and below its own position.
- Code 2 is a segmented adder. Carries are cut at the boundaries between blocks of BPB bits, and the most significant segment is L blocks wide.
- Code 3 is an exact ripple adder.

An anti-bias option changes the carry-in wherever a carry chain is cut. Without it, the carry-in is constant zero. With it, the carry-in is the first row's bit just below the cut, so the errors centre on zero instead of always pulling the result low.

The block is meant for error-tolerant kernels such as dot products and distance sums. There, a small and bounded product error buys a shorter and cheaper final adder.

Top module: `approx_mult`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `out_valid` is 0 and `prod_o` is all zeros.
- R2: A cycle with `in_valid` high updates `prod_o` at the next rising edge and raises `out_valid` for that one cycle. A cycle with `in_valid` low leaves `prod_o` unchanged and drives `out_valid` to 0.
- R3: With adder code 0 or 3, `prod_o` equals the two's-complement product of the signed operands in all 2W bits, including the cases (−2^(W−1))², zero and −1. The two rows produced by the compressor tree always sum, modulo 2^(2W), to that product.
- R4: With adder code 1, product bits [K−1:0] always equal those of the exact product, with or without anti-bias.
- R5: With anti-bias off, codes 1 and 2 give the exact product whenever the multiplier's sign bit is 0 and it has at most one bit set.
- R6: With code 2 and anti-bias off, (exact − `prod_o`) mod 2^(2W) has ones only at the cut positions BPB·j for j = 1 … 2W/BPB − L. Product bits [BPB−1:0] are always exact.
- R7: With code 2 and anti-bias on, the signed error (exact − `prod_o`) has a magnitude of at most the sum of 2^p over the cut positions p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on the inputs are to be multiplied this cycle |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| out_valid | output | 1 | `prod_o` holds a fresh result |
| prod_o | output | 2W | Registered signed product |

## Verification
The assertions check four things on every clock: the latency and hold rule, that the compressor tree's two rows sum to the true product, that the ripple adder is exact, and the windowed and segmented error structure against the exact sum of the same two rows. Other behaviour shows only in the bench's scenarios. These include the reset value, the exact result at the extreme operands, exactness for single-bit multipliers, and the error bound under anti-bias. The bench runs several copies of the block side by side, one for each adder variant, on the same operand stream.

// File: rtl/approx_mult_pkg.sv
`timescale 1ns/1ps
package approx_mult_pkg;

  localparam int ADD_PREFIX  = 0;
  localparam int ADD_WINDOW  = 1;
  localparam int ADD_SEGMENT = 2;
  localparam int ADD_RIPPLE  = 3;

  // rows left after lv levels of 3:2 reduction starting from r0 rows
  function automatic int rows_at(int r0, int lv);
    int m;
    m = r0;
    for (int i = 0; i < lv; i++) m = 2 * (m / 3) + (m % 3);
    return m;
  endfunction

  // levels needed to reach two rows
  function automatic int tree_levels(int r0);
    int m;
    int n;
    m = r0;
    n = 0;
    while (m > 2) begin
      m = 2 * (m / 3) + (m % 3);
      n++;
    end
    return n;
  endfunction

  // one-hot marks at every cut position of the segmented adder
  function automatic logic [127:0] seg_cuts(int w2, int bpb, int l);
    logic [127:0] m;
    m = '0;
    for (int j = 1; j <= (w2 / bpb) - l; j++) m[j * bpb] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/am_pp_gen.sv
`timescale 1ns/1ps
module am_pp_gen #(
  parameter int W = 16,
  localparam int W2 = 2 * W,
  localparam int R0 = W + 1
) (
  input  logic [W-1:0]           mcand,
  input  logic [W-1:0]           mplier,
  output logic [R0-1:0][W2-1:0]  rows
);
  logic [W2-1:0] mc_ext;
  assign mc_ext = {{W{mcand[W-1]}}, mcand};

  generate
    for (genvar i = 0; i < W - 1; i++) begin : g_pos
      assign rows[i] = mplier[i] ? (mc_ext << i) : '0;
    end
  endgenerate

  // sign bit carries weight -2^(W-1): add the ones' complement here, +1 below
  assign rows[W-1] = mplier[W-1] ? ~(mc_ext << (W - 1)) : '0;
  assign rows[W]   = {{(W2-1){1'b0}}, mplier[W-1]};
endmodule

// File: rtl/am_csa_row.sv
`timescale 1ns/1ps
module am_csa_row #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  assign s  = a ^ b ^ c;
  assign cy = {((a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0])), 1'b0};
endmodule

// File: rtl/am_wallace.sv
`timescale 1ns/1ps
module am_wallace
  import approx_mult_pkg::*;
#(
  parameter int W = 16,
  localparam int W2 = 2 * W,
  localparam int R0 = W + 1,
  localparam int NLEV = tree_levels(R0)
) (
  input  logic [R0-1:0][W2-1:0] rows,
  output logic [W2-1:0]         row_x,
  output logic [W2-1:0]         row_y
);
  logic [W2-1:0] lvl [NLEV+1][R0];

  generate
    for (genvar r = 0; r < R0; r++) begin : g_in
      assign lvl[0][r] = rows[r];
    end
    for (genvar l = 0; l < NLEV; l++) begin : g_lvl
      localparam int CUR = rows_at(R0, l);
      localparam int NT  = CUR / 3;
      localparam int NXT = rows_at(R0, l + 1);
      for (genvar t = 0; t < NT; t++) begin : g_csa
        am_csa_row #(.W(W2)) u_csa (
          .a (lvl[l][3*t]),
          .b (lvl[l][3*t+1]),
          .c (lvl[l][3*t+2]),
          .s (lvl[l+1][2*t]),
          .cy(lvl[l+1][2*t+1])
        );
      end
      for (genvar p = 0; p < CUR - 3 * NT; p++) begin : g_pass
        assign lvl[l+1][2*NT+p] = lvl[l][3*NT+p];
      end
      for (genvar z = NXT; z < R0; z++) begin : g_zero
        assign lvl[l+1][z] = '0;
      end
    end
  endgenerate

  assign row_x = lvl[NLEV][0];
  assign row_y = lvl[NLEV][1];
endmodule

// File: rtl/am_final_adder.sv
`timescale 1ns/1ps
module am_final_adder
  import approx_mult_pkg::*;
#(
  parameter int W2        = 32,
  parameter int ADD_SEL   = ADD_RIPPLE,
  parameter int WIN_K     = 8,
  parameter int SEG_BPB   = 4,
  parameter int SEG_L     = 2,
  parameter bit ANTI_BIAS = 1'b0,
  localparam int KE   = (WIN_K > W2) ? W2 : WIN_K,
  localparam int NB   = W2 / SEG_BPB,
  localparam int NLOW = NB - SEG_L,
  localparam int TW   = SEG_L * SEG_BPB,
  localparam int TB   = NLOW * SEG_BPB
) (
  input  logic [W2-1:0] x,
  input  logic [W2-1:0] y,
  output logic [W2-1:0] s
);
  generate
    if (ADD_SEL == ADD_PREFIX) begin : g_prefix
      assign s = x + y;
    end else if (ADD_SEL == ADD_RIPPLE) begin : g_ripple
      logic [W2-1:0] cr;
      always_comb begin
        cr[0] = 1'b0;
        for (int i = 0; i < W2 - 1; i++) begin
          cr[i+1] = (x[i] & y[i]) | (x[i] & cr[i]) | (y[i] & cr[i]);
        end
      end
      assign s = x ^ y ^ cr;
    end else if (ADD_SEL == ADD_WINDOW) begin : g_window
      logic [KE-1:0] lo;
      assign lo = x[KE-1:0] + y[KE-1:0];
      for (genvar i = 0; i < W2; i++) begin : g_bit
        if (i < KE) begin : g_exact
          assign s[i] = lo[i];
        end else begin : g_spec
          logic          cin;
          logic [KE-1:0] ws;
          assign cin  = ANTI_BIAS ? x[i-KE] : 1'b0;
          assign ws   = x[i -: KE] + y[i -: KE] + {{(KE-1){1'b0}}, cin};
          assign s[i] = ws[KE-1];
        end
      end
    end else begin : g_segment
      for (genvar j = 0; j < NLOW; j++) begin : g_blk
        logic cin;
        if (ANTI_BIAS && j > 0) begin : g_ab
          assign cin = x[j*SEG_BPB-1];
        end else begin : g_nab
          assign cin = 1'b0;
        end
        assign s[j*SEG_BPB +: SEG_BPB] = x[j*SEG_BPB +: SEG_BPB] + y[j*SEG_BPB +: SEG_BPB]
                                         + {{(SEG_BPB-1){1'b0}}, cin};
      end
      logic tcin;
      if (ANTI_BIAS && NLOW > 0) begin : g_tab
        assign tcin = x[TB-1];
      end else begin : g_tnab
        assign tcin = 1'b0;
      end
      assign s[TB +: TW] = x[TB +: TW] + y[TB +: TW] + {{(TW-1){1'b0}}, tcin};
    end
  endgenerate
endmodule

// File: rtl/approx_mult.sv
`timescale 1ns/1ps
module approx_mult
  import approx_mult_pkg::*;
#(
  parameter int W         = 16,
  parameter int ADD_SEL   = ADD_RIPPLE,
  parameter int WIN_K     = 8,
  parameter int SEG_BPB   = 4,
  parameter int SEG_L     = 2,
  parameter bit ANTI_BIAS = 1'b0,
  localparam int W2 = 2 * W,
  localparam int R0 = W + 1,
  localparam int KE = (WIN_K > W2) ? W2 : WIN_K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic          out_valid,
  output logic [W2-1:0] prod_o
);
  localparam logic [127:0] CUTS_FULL = seg_cuts(W2, SEG_BPB, SEG_L);
  localparam logic [W2-1:0] CUTS = CUTS_FULL[W2-1:0];

  logic [R0-1:0][W2-1:0] pp_rows;
  logic [W2-1:0]         row_x, row_y, sum_w;
  logic [W2-1:0]         prod_d, prod_q;
  logic                  vld_d, vld_q;

  am_pp_gen #(.W(W)) u_pp (
    .mcand (mcand_i),
    .mplier(mplier_i),
    .rows  (pp_rows)
  );

  am_wallace #(.W(W)) u_tree (
    .rows (pp_rows),
    .row_x(row_x),
    .row_y(row_y)
  );

  am_final_adder #(
    .W2(W2), .ADD_SEL(ADD_SEL), .WIN_K(WIN_K),
    .SEG_BPB(SEG_BPB), .SEG_L(SEG_L), .ANTI_BIAS(ANTI_BIAS)
  ) u_add (
    .x(row_x),
    .y(row_y),
    .s(sum_w)
  );

  // next-state
  always_comb begin
    vld_d  = in_valid;
    prod_d = prod_q;
    if (in_valid) prod_d = sum_w;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      vld_q  <= vld_d;
      prod_q <= prod_d;
    end
  end

  assign out_valid = vld_q;
  assign prod_o    = prod_q;

  // ---------------- checks ----------------
  logic        [W2-1:0] exact_sum;
  logic signed [W2-1:0] a_sx, b_sx, ref_p;
  assign exact_sum = row_x + row_y;
  assign a_sx      = {{W{mcand_i[W-1]}}, mcand_i};
  assign b_sx      = {{W{mplier_i[W-1]}}, mplier_i};
  assign ref_p     = a_sx * b_sx;

  assert_tree_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exact_sum == ref_p);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(prod_o)));

  generate
    if (ADD_SEL == ADD_RIPPLE) begin : g_chk_rip
      assert_ripple_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_w == exact_sum);
    end
    if (ADD_SEL == ADD_WINDOW) begin : g_chk_win
      assert_win_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_w[KE-1:0] == exact_sum[KE-1:0]);
    end
    if (ADD_SEL == ADD_SEGMENT && !ANTI_BIAS) begin : g_chk_seg
      assert_seg_cuts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((exact_sum - sum_w) & ~CUTS) == '0);
    end
  endgenerate
endmodule

// File: tb/approx_mult_bench.sv
`timescale 1ns/1ps
module approx_mult_bench;
  localparam int W   = 16;
  localparam int W2  = 2 * W;
  localparam int K   = 8;
  localparam int BPB = 4;
  localparam int L   = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [W-1:0] a, b;

  logic          v_rip, v_pfx, v_win, v_wab, v_seg, v_sab;
  logic [W2-1:0] p_rip, p_pfx, p_win, p_wab, p_seg, p_sab;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  approx_mult #(.W(W), .ADD_SEL(3)) u_approx_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mcand_i(a), .mplier_i(b),
    .out_valid(v_rip), .prod_o(p_rip));
  approx_mult #(.W(W), .ADD_SEL(0)) u_pfx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mcand_i(a), .mplier_i(b),
    .out_valid(v_pfx), .prod_o(p_pfx));
  approx_mult #(.W(W), .ADD_SEL(1), .WIN_K(K), .ANTI_BIAS(1'b0)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mcand_i(a), .mplier_i(b),
    .out_valid(v_win), .prod_o(p_win));
  approx_mult #(.W(W), .ADD_SEL(1), .WIN_K(K), .ANTI_BIAS(1'b1)) u_wab (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mcand_i(a), .mplier_i(b),
    .out_valid(v_wab), .prod_o(p_wab));
  approx_mult #(.W(W), .ADD_SEL(2), .SEG_BPB(BPB), .SEG_L(L), .ANTI_BIAS(1'b0)) u_seg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mcand_i(a), .mplier_i(b),
    .out_valid(v_seg), .prod_o(p_seg));
  approx_mult #(.W(W), .ADD_SEL(2), .SEG_BPB(BPB), .SEG_L(L), .ANTI_BIAS(1'b1)) u_sab (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mcand_i(a), .mplier_i(b),
    .out_valid(v_sab), .prod_o(p_sab));

  // reference model state
  logic [W2-1:0] exp_q[$];
  logic [W2-1:0] cut_mask;
  longint        cut_bound;

  function automatic logic [W2-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return p[W2-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_result(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W2-1:0] e, d;
    longint sd;
    bit single;
    e = exp_q.pop_front();
    single = (y[W-1] == 1'b0) && ($countones(y) <= 1);
    chk(v_rip && v_pfx && v_win && v_wab && v_seg && v_sab, "R2 valid", {v_rip, v_sab}, 2'b11);
    chk(p_rip == e, "R3 ripple exact", p_rip, e);
    chk(p_pfx == e, "R3 prefix exact", p_pfx, e);
    chk(p_win[K-1:0] == e[K-1:0], "R4 window low bits", p_win[K-1:0], e[K-1:0]);
    chk(p_wab[K-1:0] == e[K-1:0], "R4 window anti-bias low bits", p_wab[K-1:0], e[K-1:0]);
    if (single) begin
      chk(p_win == e, "R5 window single-bit multiplier", p_win, e);
      chk(p_seg == e, "R5 segment single-bit multiplier", p_seg, e);
    end
    d = e - p_seg;
    chk((d & ~cut_mask) == '0, "R6 error only at cuts", d, d & cut_mask);
    chk(p_seg[BPB-1:0] == e[BPB-1:0], "R6 low block exact", p_seg[BPB-1:0], e[BPB-1:0]);
    d  = e - p_sab;
    sd = longint'($signed(d));
    if (sd < 0) sd = -sd;
    chk(sd <= cut_bound, "R7 anti-bias error bound", sd, cut_bound);
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    in_valid = 1'b1;
    a = x;
    b = y;
    exp_q.push_back(ref_mul(x, y));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(x, y);
  endtask

  task automatic idle_cycle();
    logic [W2-1:0] h_rip, h_seg, h_wab;
    h_rip = p_rip; h_seg = p_seg; h_wab = p_wab;
    in_valid = 1'b0;
    a = W'($urandom);
    b = W'($urandom);
    @(posedge clk);
    @(negedge clk);
    chk(!v_rip && !v_seg, "R2 valid drops when idle", {v_rip, v_seg}, 0);
    chk(p_rip == h_rip && p_seg == h_seg && p_wab == h_wab, "R2 product held", p_rip, h_rip);
  endtask

  initial begin
    logic [W-1:0] corners [8];
    cut_mask  = '0;
    cut_bound = 0;
    for (int j = 1; j <= W2 / BPB - L; j++) begin
      cut_mask[j*BPB] = 1'b1;
      cut_bound += longint'(1) << (j * BPB);
    end
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h5555, 16'hAAAA, 16'h00FF};

    rst_n = 1'b0;
    in_valid = 1'b0;
    a = '0;
    b = '0;
    repeat (3) @(negedge clk);
    chk(!v_rip && !v_seg && !v_wab, "R1 valid in reset", {v_rip, v_seg}, 0);
    chk(p_rip == '0 && p_pfx == '0 && p_seg == '0 && p_sab == '0, "R1 product in reset", p_rip, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!v_rip && p_rip == '0, "R1 state after release", p_rip, 0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        apply(corners[i], corners[j]);
      end
    end
    idle_cycle();
    idle_cycle();

    for (int i = 0; i < W - 1; i++) begin
      apply(W'($urandom), W'(1) << i);
      apply(16'h8000, W'(1) << i);
    end
    apply(W'($urandom), 16'h0000);
    idle_cycle();

    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom));
      if (i % 50 == 0) idle_cycle();
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule